// File: doc/BRIEF.md
# Two-Stage Fetch Front End with Redirect Squash

This block is the front end of a small 16-bit processor built as a two-stage pipeline: a fetch stage and an execute stage, with one pipeline register between them. It owns the program counter and drives the address of a separate instruction memory. The memory holds one 16-bit word per address and returns data in the same cycle. On every clock edge the block captures the fetched word, together with its address, into the execute-stage register.

The execute stage reports control transfers through a redirect flag and a target address. A redirect from a live execute-stage instruction makes the block load the target into the program counter. In the same edge it squashes the one word that was fetched behind the transfer: that word enters the execute slot as a no-op with its valid bit clear. When no redirect is raised, the next word proceeds normally, so software never sees a delay slot. A redirect raised while the execute slot is empty or squashed is ignored. Execute-side logic outside this block must suppress register writes, memory writes and redirects whenever the valid bit is low.

The execute slot is tracked by a three-state machine:
- SLOT_EMPTY is entered on reset.
- SLOT_LIVE holds a valid instruction.
- SLOT_KILLED holds a squashed no-op.

From any state, a live redirect (allowed only in SLOT_LIVE) moves the machine to SLOT_KILLED. Every other edge out of reset moves it to SLOT_LIVE. Reset forces SLOT_EMPTY.

Top module: `fetch_kill_unit`

## Requirements
- R1: A synchronous reset sets the fetch address to 0x0000, clears the execute valid bit, and sets the execute word to the no-op value 0x0000 and the execute PC to 0x0000.
- R2: With no honoured redirect, the fetch address advances by exactly one each cycle.
- R3: A sequential advance from 0xFFFF wraps the fetch address to 0x0000.
- R4: With no honoured redirect, on the next edge the execute word and execute PC take the word and address fetched in the cycle before, and the execute valid bit is set.
- R5: A redirect raised while the execute valid bit is 1 makes the fetch address equal the redirect target in the following cycle.
- R6: The word fetched in the cycle of an honoured redirect enters the execute slot with the valid bit 0 and the execute word forced to the no-op value 0x0000.
- R7: A redirect raised while the execute valid bit is 0 has no effect: the fetch address still advances by one and the next slot is valid.
- R8: Exactly one slot is squashed per honoured redirect: the cycle after the squash shows a valid execute instruction whose PC is the redirect target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, never gated |
| rst | input | 1 | Synchronous active-high reset |
| imem_rdata | input | 16 | Instruction word read at imem_addr in the same cycle |
| redir_valid | input | 1 | Execute stage requests a control transfer |
| redir_target | input | 16 | Word address of the transfer target |
| imem_addr | output | 16 | Current program counter, used as the instruction memory address |
| ex_instr | output | 16 | Instruction held in the execute stage |
| ex_pc | output | 16 | Address of the execute-stage instruction |
| ex_valid | output | 1 | Execute-stage instruction may change state |

## Verification
The hardest cases to reach are the redirects that must be ignored. These come from a redirect held high across two consecutive cycles, where the second falls on the squashed slot, and from a redirect raised in the first cycle after reset, while the slot is still empty. The stimulus holds the redirect flag for back-to-back cycles and asserts it straight out of reset. It also redirects to 0xFFFD so that the sequential path crosses the wrap point. A long stretch of random redirect patterns follows, compared every cycle against a behavioural model.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    typedef enum logic [1:0] {
        SLOT_EMPTY  = 2'd0,
        SLOT_LIVE   = 2'd1,
        SLOT_KILLED = 2'd2
    } slot_state_t;

endpackage

// File: rtl/fetch_pc.sv
module fetch_pc #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_target,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] pc
);
    localparam logic [AW-1:0] STEP = {{(AW-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst)
            pc <= '0;
        else if (load_target)
            pc <= target;
        else
            pc <= pc + STEP;
    end
endmodule

// File: rtl/fetch_slot_reg.sv
module fetch_slot_reg #(
    parameter int            AW       = 16,
    parameter int            IW       = 16,
    parameter logic [IW-1:0] NOP_WORD = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          squash,
    input  logic [IW-1:0] fetch_word,
    input  logic [AW-1:0] fetch_addr,
    output logic [IW-1:0] slot_word,
    output logic [AW-1:0] slot_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_word <= NOP_WORD;
            slot_addr <= '0;
        end else begin
            slot_word <= squash ? NOP_WORD : fetch_word;
            slot_addr <= fetch_addr;
        end
    end
endmodule

// File: rtl/fetch_kill_unit.sv
module fetch_kill_unit
    import fetch_pkg::*;
#(
    parameter int            AW       = 16,
    parameter int            IW       = 16,
    parameter logic [IW-1:0] NOP_WORD = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] imem_rdata,
    input  logic          redir_valid,
    input  logic [AW-1:0] redir_target,
    output logic [AW-1:0] imem_addr,
    output logic [IW-1:0] ex_instr,
    output logic [AW-1:0] ex_pc,
    output logic          ex_valid
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    slot_state_t state_q, state_d;
    logic        take_redirect;

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= SLOT_EMPTY;
        else
            state_q <= state_d;
    end

    // outputs and next state
    always_comb begin
        ex_valid      = 1'b0;
        take_redirect = 1'b0;
        state_d       = SLOT_LIVE;
        unique case (state_q)
            SLOT_LIVE: begin
                ex_valid      = 1'b1;
                take_redirect = redir_valid;
                state_d       = redir_valid ? SLOT_KILLED : SLOT_LIVE;
            end
            SLOT_EMPTY,
            SLOT_KILLED: begin
                ex_valid      = 1'b0;
                take_redirect = 1'b0;
                state_d       = SLOT_LIVE;
            end
            default: begin
                ex_valid      = 1'b0;
                take_redirect = 1'b0;
                state_d       = SLOT_EMPTY;
            end
        endcase
    end

    fetch_pc #(.AW(AW)) u_pc (
        .clk         (clk),
        .rst         (rst),
        .load_target (take_redirect),
        .target      (redir_target),
        .pc          (imem_addr)
    );

    fetch_slot_reg #(.AW(AW), .IW(IW), .NOP_WORD(NOP_WORD)) u_slot (
        .clk        (clk),
        .rst        (rst),
        .squash     (take_redirect),
        .fetch_word (imem_rdata),
        .fetch_addr (imem_addr),
        .slot_word  (ex_instr),
        .slot_addr  (ex_pc)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (imem_addr == '0 && !ex_valid && ex_instr == NOP_WORD));

    // R2
    seq_advance_chk: assert property (@(posedge clk) disable iff (rst)
        !(redir_valid && ex_valid) |=> imem_addr == $past(imem_addr) + ONE);

    // R4
    slot_capture_chk: assert property (@(posedge clk) disable iff (rst)
        !(redir_valid && ex_valid) |=>
            (ex_valid && ex_pc == $past(imem_addr) && ex_instr == $past(imem_rdata)));

    // R5
    redirect_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (redir_valid && ex_valid) |=> imem_addr == $past(redir_target));

    // R6
    squash_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (redir_valid && ex_valid) |=> (!ex_valid && ex_instr == NOP_WORD));

    // R7
    ignored_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        (redir_valid && !ex_valid) |=> ex_valid);

    // R8
    single_squash_chk: assert property (@(posedge clk) disable iff (rst)
        (ex_valid && redir_valid) |=> ##1 (ex_valid || $past(rst)));
endmodule

// File: tb/fetch_kill_unit_tb.sv
module fetch_kill_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] imem_rdata;
    logic        redir_valid = 1'b0;
    logic [15:0] redir_target = 16'h0000;
    logic [15:0] imem_addr;
    logic [15:0] ex_instr;
    logic [15:0] ex_pc;
    logic        ex_valid;

    always #4 clk = ~clk; // 125 MHz

    function automatic logic [15:0] mem_word(input logic [15:0] a);
        return (a * 16'd40503) ^ 16'h5A3C ^ {a[7:0], a[15:8]};
    endfunction

    assign imem_rdata = mem_word(imem_addr);

    fetch_kill_unit u_dut (
        .clk          (clk),
        .rst          (rst),
        .imem_rdata   (imem_rdata),
        .redir_valid  (redir_valid),
        .redir_target (redir_target),
        .imem_addr    (imem_addr),
        .ex_instr     (ex_instr),
        .ex_pc        (ex_pc),
        .ex_valid     (ex_valid)
    );

    // behavioural reference model
    int          m_pc = 0;
    bit          m_valid = 0;
    int          m_instr = 0;
    int          m_expc = 0;
    string       tag_addr = "R1";
    string       tag_slot = "R1";
    bit          last_take = 0;
    int          checks = 0;
    int          fails = 0;

    always @(posedge clk) begin
        bit take;
        if (rst) begin
            m_pc = 0; m_valid = 0; m_instr = 0; m_expc = 0;
            tag_addr = "R1"; tag_slot = "R1"; last_take = 0;
        end else begin
            take = redir_valid && m_valid;
            if (take)                       tag_addr = "R5";
            else if (redir_valid)           tag_addr = "R7";
            else if (m_pc == 16'hFFFF)      tag_addr = "R3";
            else                            tag_addr = "R2";
            if (take)                       tag_slot = "R6";
            else if (last_take)             tag_slot = "R8";
            else if (redir_valid)           tag_slot = "R7";
            else                            tag_slot = "R4";
            m_expc  = m_pc;
            m_instr = take ? 0 : int'(mem_word(16'(m_pc)));
            m_valid = !take;
            m_pc    = take ? int'(redir_target) : (m_pc + 1) % 65536;
            last_take = take;
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        check(tag_addr, "imem_addr", int'(imem_addr), m_pc);
        check(tag_slot, "ex_valid",  int'(ex_valid),  int'(m_valid));
        check(tag_slot, "ex_instr",  int'(ex_instr),  m_instr);
        check(tag_slot, "ex_pc",     int'(ex_pc),     m_expc);
    end

    task automatic step(input bit rv, input logic [15:0] tgt);
        @(negedge clk);
        #1;
        redir_valid  = rv;
        redir_target = tgt;
    endtask

    bit done = 0;

    initial begin
        // R1: reset, with a redirect attempt held during reset
        step(1'b1, 16'h1234);
        step(1'b1, 16'h1234);
        step(1'b0, 16'h0000);
        rst = 1'b0;
        // R7: redirect straight out of reset while the slot is empty
        step(1'b1, 16'h0400);
        // R2 / R4: sequential run
        for (int i = 0; i < 8; i++) step(1'b0, 16'h0000);
        // R5 / R6 / R8: single redirect
        step(1'b1, 16'h0200);
        for (int i = 0; i < 4; i++) step(1'b0, 16'h0000);
        // R7: redirect held two cycles, second lands on squashed slot
        step(1'b1, 16'h0300);
        step(1'b1, 16'h0999);
        for (int i = 0; i < 4; i++) step(1'b0, 16'h0000);
        // R3: redirect near top and cross the wrap
        step(1'b1, 16'hFFFD);
        for (int i = 0; i < 8; i++) step(1'b0, 16'h0000);
        // random patterns
        for (int i = 0; i < 2000; i++)
            step(($urandom % 4) == 0, 16'($urandom));
        // reset mid-run
        rst = 1'b1;
        step(1'b0, 16'h0000);
        step(1'b0, 16'h0000);
        rst = 1'b0;
        for (int i = 0; i < 6; i++) step(1'b0, 16'h0000);
        done = 1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule